// File: doc/BRIEF.md
# Input Capture Channel Front-End

This block is one capture channel of a timer. An asynchronous pin is brought into the clock domain and then passed through a digital noise filter. A level change is accepted only after it has been seen on a programmable number of consecutive samples. On the filtered level, an edge detector picks either rising or falling transitions. Each detected edge leaves the block as a one-cycle trigger pulse that other timer logic can use.

The same edge events pass through a capture divider that lets through every 1st, 2nd, 4th or 8th event. Each event that passes copies the running counter value into a capture register and raises a capture flag. A capture that lands while the flag is still up also raises an overcapture flag. Software reads the register and acknowledges the flags through strobes. When the channel is disabled, it produces no triggers or captures and its divider starts again from zero.

Top module: `capchan_top`

## Requirements
- R1: A new pin level reaches the filtered signal only after `filtLen`+1 consecutive equal synchronized samples (`filtLen` 0..7 gives 1..8 samples). A shorter excursion produces no trigger and no capture.
- R2: With `filtLen`=0, a pin change set up before clock edge k produces the trigger pulse in the cycle after edge k+2. This is two synchronizer stages plus one filter/edge register.
- R3: `polSel`=0 selects rising edges and `polSel`=1 selects falling edges of the filtered signal. `trigPulse` is high for exactly one clock per selected edge.
- R4: `pscSel` codes 2'b00, 2'b01, 2'b10 and 2'b11 cause a capture on every 1st, 2nd, 4th and 8th selected edge respectively.
- R5: On a capture, `capReg` takes the value of `cntVal` at the same clock edge that raises `trigPulse`, and `capFlag` is set.
- R6: `capReg` holds its value in every cycle without a capture.
- R7: A capture while `capFlag` is already set raises `ovrFlag`.
- R8: `capRead` clears `capFlag`. `flagClr` clears both `capFlag` and `ovrFlag`. A capture in the same cycle as a clear leaves `capFlag` set.
- R9: While `chanEn` is low, no trigger and no capture occur, and the divider event count returns to zero.
- R10: After reset, `capReg`, `capFlag`, `ovrFlag` and `trigPulse` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pinIn | input | 1 | Asynchronous capture pin |
| cntVal | input | CNT_W (16) | Running timer counter value |
| filtLen | input | FILT_W (3) | Filter length code: samples required minus one |
| polSel | input | 1 | Edge select: 0 rising, 1 falling |
| pscSel | input | PSC_W (2) | Capture divider code |
| chanEn | input | 1 | Channel enable |
| flagClr | input | 1 | Clears capture and overcapture flags |
| capRead | input | 1 | Register read strobe; clears capture flag |
| capReg | output | CNT_W (16) | Captured counter value |
| capFlag | output | 1 | Capture flag |
| ovrFlag | output | 1 | Overcapture flag |
| trigPulse | output | 1 | One-cycle trigger on each selected edge |

## Verification
The bench builds the block with its defaults: a 16-bit counter, a 3-bit filter code and a 2-bit divider code. With these settings the longest filter (8 samples) and the deepest divider (every 8th edge) can both be reached within short pulse trains. The bench drives the counter input as a free-running count, so every capture gives a distinct value. It tests both filter boundaries (pulses one sample short of the filter length, and pulses exactly at it), both edge polarities, all divider codes, and a clear that lands in the same cycle as a capture.

// File: rtl/capchan_pkg.sv
package capchan_pkg;
  // Strobes from the control half to the datapath half
  typedef struct packed {
    logic edgeNow;  // selected filtered edge in this cycle
    logic capNow;   // edge that survives the divider
  } capStrobe_t;
endpackage

// File: rtl/capchan_ctrl.sv
module capchan_ctrl
  import capchan_pkg::*;
#(
  parameter int FILT_W      = 3,
  parameter int PSC_W       = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pinIn,
  input  logic [FILT_W-1:0] filtLen,
  input  logic              polSel,
  input  logic [PSC_W-1:0]  pscSel,
  input  logic              chanEn,
  output capStrobe_t        strb,
  output logic              trigPulse
);
  localparam int PCNT_W = (1 << PSC_W) - 1;

  // Synchronizer chain
  logic [SYNC_STAGES-1:0] syncQ;
  genvar g;
  generate
    for (g = 0; g < SYNC_STAGES; g++) begin : gSync
      if (g == 0) begin : gFirst
        always_ff @(posedge clk or negedge rstN)
          if (!rstN) syncQ[g] <= 1'b0;
          else       syncQ[g] <= pinIn;
      end else begin : gRest
        always_ff @(posedge clk or negedge rstN)
          if (!rstN) syncQ[g] <= 1'b0;
          else       syncQ[g] <= syncQ[g-1];
      end
    end
  endgenerate

  logic sampled;
  assign sampled = syncQ[SYNC_STAGES-1];

  // Run-length filter
  logic              filtLvl;
  logic [FILT_W-1:0] runCnt;
  logic              differs, flip;

  assign differs = (sampled != filtLvl);
  assign flip    = differs && (runCnt == filtLen);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      filtLvl <= 1'b0;
      runCnt  <= '0;
    end else if (!differs || flip) begin
      runCnt  <= '0;
      if (flip) filtLvl <= sampled;
    end else begin
      runCnt  <= runCnt + 1'b1;
    end
  end

  // Edge select: new level 1 with polSel 0, new level 0 with polSel 1
  logic edgeNow;
  assign edgeNow = flip && chanEn && (sampled ^ polSel);

  // Capture divider
  logic [PCNT_W-1:0] psCnt, termCnt;
  always_comb begin
    termCnt = '0;
    for (int i = 0; i < PCNT_W; i++) termCnt[i] = (i < int'(pscSel));
  end

  logic capNow;
  assign capNow = edgeNow && (psCnt == termCnt);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         psCnt <= '0;
    else if (!chanEn)  psCnt <= '0;
    else if (edgeNow)  psCnt <= capNow ? '0 : psCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) trigPulse <= 1'b0;
    else       trigPulse <= edgeNow;

  assign strb.edgeNow = edgeNow;
  assign strb.capNow  = capNow;
endmodule

// File: rtl/capchan_datapath.sv
module capchan_datapath
  import capchan_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  capStrobe_t       strb,
  input  logic [CNT_W-1:0] cntVal,
  input  logic             flagClr,
  input  logic             capRead,
  output logic [CNT_W-1:0] capReg,
  output logic             capFlag,
  output logic             ovrFlag
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      capReg  <= '0;
      capFlag <= 1'b0;
      ovrFlag <= 1'b0;
    end else begin
      if (strb.capNow) capReg <= cntVal;

      if (strb.capNow)              capFlag <= 1'b1;
      else if (flagClr || capRead)  capFlag <= 1'b0;

      if (strb.capNow && capFlag)   ovrFlag <= 1'b1;
      else if (flagClr)             ovrFlag <= 1'b0;
    end
  end
endmodule

// File: rtl/capchan_top.sv
module capchan_top
  import capchan_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int FILT_W = 3,
  parameter int PSC_W  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pinIn,
  input  logic [CNT_W-1:0]  cntVal,
  input  logic [FILT_W-1:0] filtLen,
  input  logic              polSel,
  input  logic [PSC_W-1:0]  pscSel,
  input  logic              chanEn,
  input  logic              flagClr,
  input  logic              capRead,
  output logic [CNT_W-1:0]  capReg,
  output logic              capFlag,
  output logic              ovrFlag,
  output logic              trigPulse
);
  capStrobe_t strb;

  capchan_ctrl #(.FILT_W(FILT_W), .PSC_W(PSC_W), .SYNC_STAGES(2)) ctrl_i (
    .clk(clk), .rstN(rstN), .pinIn(pinIn), .filtLen(filtLen), .polSel(polSel),
    .pscSel(pscSel), .chanEn(chanEn), .strb(strb), .trigPulse(trigPulse)
  );

  capchan_datapath #(.CNT_W(CNT_W)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .cntVal(cntVal), .flagClr(flagClr),
    .capRead(capRead), .capReg(capReg), .capFlag(capFlag), .ovrFlag(ovrFlag)
  );
endmodule

// File: rtl/capchan_checker.sv
module capchan_checker
  import capchan_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             chanEn,
  input logic [CNT_W-1:0] cntVal,
  input logic [CNT_W-1:0] capReg,
  input logic             capFlag,
  input logic             ovrFlag,
  input logic             trigPulse,
  input capStrobe_t       strb
);
  AST_TRIG_ONE_WIDE: assert property (@(posedge clk) disable iff (!rstN)
    trigPulse |=> !trigPulse);                                           // R3
  AST_CAP_LOADS: assert property (@(posedge clk) disable iff (!rstN)
    strb.capNow |=> (capReg == $past(cntVal)) && capFlag);               // R5
  AST_CAP_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !strb.capNow |=> $stable(capReg));                                   // R6
  AST_OVR_RAISE: assert property (@(posedge clk) disable iff (!rstN)
    (strb.capNow && capFlag) |=> ovrFlag);                               // R7
  AST_FLAG_NEEDS_TRIG: assert property (@(posedge clk) disable iff (!rstN)
    $rose(capFlag) |-> trigPulse);                                       // R5
  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !chanEn |=> !trigPulse && $stable(capReg));                          // R9
endmodule

bind capchan_top capchan_checker #(.CNT_W(CNT_W)) chk_i (
  .clk(clk), .rstN(rstN), .chanEn(chanEn), .cntVal(cntVal), .capReg(capReg),
  .capFlag(capFlag), .ovrFlag(ovrFlag), .trigPulse(trigPulse), .strb(strb)
);

// File: tb/capchan_top_tb_top.sv
`timescale 1ns/1ps
module capchan_top_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        pinIn = 1'b0;
  logic [15:0] cntVal = '0;
  logic [2:0]  filtLen = '0;
  logic        polSel = 1'b0;
  logic [1:0]  pscSel = '0;
  logic        chanEn = 1'b0;
  logic        flagClr = 1'b0;
  logic        capRead = 1'b0;
  logic [15:0] capReg;
  logic        capFlag, ovrFlag, trigPulse;

  int nChecks = 0;
  int nFails  = 0;

  always #2.5 clk = ~clk;  // 200 MHz
  always @(posedge clk) cntVal <= cntVal + 16'd1;

  capchan_top dut_i (
    .clk(clk), .rstN(rstN), .pinIn(pinIn), .cntVal(cntVal), .filtLen(filtLen),
    .polSel(polSel), .pscSel(pscSel), .chanEn(chanEn), .flagClr(flagClr),
    .capRead(capRead), .capReg(capReg), .capFlag(capFlag), .ovrFlag(ovrFlag),
    .trigPulse(trigPulse)
  );

  // Event counters sampled away from the active edge
  logic        counting = 1'b0;
  int          trigCnt = 0;
  int          capCnt = 0;
  logic [15:0] lastCap = '0;
  always @(negedge clk) begin
    if (counting) begin
      if (trigPulse) trigCnt++;
      if (capReg != lastCap) capCnt++;
    end
    lastCap = capReg;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic waitN(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse(input int hi, input int lo);
    pinIn = 1'b1; waitN(hi);
    pinIn = 1'b0; waitN(lo);
  endtask

  task automatic startCount();
    trigCnt = 0; capCnt = 0; counting = 1'b1;
  endtask

  task automatic clearFlags();
    flagClr = 1'b1; waitN(1); flagClr = 1'b0;
  endtask

  // pol, psc, filt, pulses, hi, lo, expTrig, expCap
  localparam int NV = 8;
  localparam int VEC [NV][8] = '{
    '{0, 0, 0, 4, 3, 3, 4, 4},   // R3 rising, R4 every edge
    '{1, 0, 0, 4, 3, 3, 4, 4},   // R3 falling
    '{0, 1, 2, 6, 4, 4, 6, 3},   // R4 every 2nd
    '{0, 2, 0, 8, 3, 3, 8, 2},   // R4 every 4th
    '{1, 3, 1, 8, 3, 3, 8, 1},   // R4 every 8th
    '{0, 0, 3, 5, 2, 6, 0, 0},   // R1 glitch shorter than 4 samples
    '{0, 0, 7, 3, 8, 8, 3, 3},   // R1 exactly 8 samples accepted
    '{0, 0, 7, 3, 7, 9, 0, 0}    // R1 7 samples rejected
  };

  initial begin
    waitN(100000);
    nFails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    logic [15:0] held;
    waitN(3);
    // R10 reset state
    check(capReg == 0 && !capFlag && !ovrFlag && !trigPulse, "R10 reset",
          int'(capReg) + capFlag + ovrFlag + trigPulse, 0);
    rstN = 1'b1;
    waitN(2);

    for (int v = 0; v < NV; v++) begin
      chanEn = 1'b0;
      polSel = VEC[v][0][0];
      pscSel = 2'(VEC[v][1]);
      filtLen = 3'(VEC[v][2]);
      waitN(2);
      chanEn = 1'b1;
      clearFlags();
      startCount();
      for (int p = 0; p < VEC[v][3]; p++) pulse(VEC[v][4], VEC[v][5]);
      waitN(12);
      counting = 1'b0;
      check(trigCnt == VEC[v][6], $sformatf("R1/R3 triggers vec %0d", v), trigCnt, VEC[v][6]);
      check(capCnt == VEC[v][7], $sformatf("R4/R1 captures vec %0d", v), capCnt, VEC[v][7]);
    end

    // R2/R5 latency and capture value
    chanEn = 1'b1; polSel = 1'b0; pscSel = 2'd0; filtLen = 3'd0;
    waitN(4);
    clearFlags();
    waitN(2);
    pinIn = 1'b1;
    waitN(2);
    check(!trigPulse, "R2 no early trigger", trigPulse, 0);
    waitN(1);
    check(trigPulse, "R2 trigger after edge k+2", trigPulse, 1);
    check(capReg == cntVal - 16'd1, "R5 captured counter", capReg, cntVal - 16'd1);
    check(capFlag, "R5 capture flag", capFlag, 1);
    waitN(1);
    check(!trigPulse, "R3 one clock wide", trigPulse, 0);
    pinIn = 1'b0; waitN(5);
    // R7 overcapture
    check(!ovrFlag, "R7 no overcapture yet", ovrFlag, 0);
    pulse(4, 5);
    check(ovrFlag, "R7 overcapture", ovrFlag, 1);
    // R8 read clears capture flag only
    capRead = 1'b1; waitN(1); capRead = 1'b0;
    check(!capFlag && ovrFlag, "R8 read clears flag only", {capFlag, ovrFlag}, 1);
    clearFlags();
    check(!ovrFlag && !capFlag, "R8 clear both", {capFlag, ovrFlag}, 0);
    // R8 capture wins over simultaneous clear
    pinIn = 1'b1;
    waitN(2);
    flagClr = 1'b1;
    waitN(1);
    flagClr = 1'b0;
    check(capFlag, "R8 capture beats clear", capFlag, 1);
    pinIn = 1'b0; waitN(5);

    // R9/R6 disabled channel
    chanEn = 1'b0;
    held = capReg;
    startCount();
    pulse(4, 4); pulse(4, 4);
    waitN(6);
    counting = 1'b0;
    check(trigCnt == 0, "R9 no trigger disabled", trigCnt, 0);
    check(capReg == held, "R6 capReg held", capReg, held);

    // R9 divider reset by disable
    chanEn = 1'b1; pscSel = 2'd1;
    waitN(2);
    startCount();
    pulse(3, 6);
    check(capCnt == 0 && trigCnt == 1, "R4 first of two no capture", capCnt, 0);
    chanEn = 1'b0; waitN(2); chanEn = 1'b1;
    pulse(3, 6);
    check(capCnt == 0, "R9 divider restarted", capCnt, 0);
    pulse(3, 6);
    counting = 1'b0;
    check(capCnt == 1, "R4 second edge captures", capCnt, 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule